// File: doc/BRIEF.md
# Transmit Power Limit Resolver

This block turns each outgoing frame's power request into the power code that is actually sent to the transmitter. Every power quantity is a code in half-dB steps, so a code of 20 stands for 10 dBm. Three settings shape the result. The first is a device ceiling. The second is a software limit that can never sit above that ceiling. The third is a coarse global down-scale. A frame may also name an index into a 64-word table of uneven power steps. The frame uses that table entry in place of its own request only when table control has been switched on.

Settings arrive through a small write port, where a selector picks the field. The table is filled through its own address/data write port. Frames arrive on a valid/ready request port. The resolved code comes out one clock later with a valid strobe. The stored limit is visible on a readback output. The readback always shows the clamped value, never the raw value that was written.

The resolution order is fixed. The block first picks the table entry or the frame's request. It then subtracts the scale reduction. Last, it clamps the result to the limit.

Top module: `txpwr_resolver`

## Requirements
- R1: After reset, `out_valid` is 0, `lim_rd` reads the all-ones code (127 with defaults), `req_ready` is 1, the scale is 0 and table control is off.
- R2: A limit write (`cfg_sel`=1) stores min(written value, ceiling). `lim_rd` returns the stored value from the cycle after the write.
- R3: A ceiling write (`cfg_sel`=0) also lowers the stored limit to the new ceiling when the limit is above it. Raising the ceiling leaves the limit unchanged.
- R4: While table control is off (`cfg_sel`=3, bit 0 = 0), a frame with `req_use_tbl`=1 is resolved from `req_power` and not from the table.
- R5: While table control is on, a frame with `req_use_tbl`=1 uses the table word at `req_tbl_idx`, zero-extended. Words are loaded through `tbl_wr_*`, and indices 0 and 63 are both reachable. A frame with `req_use_tbl`=0 still uses `req_power`.
- R6: Scale settings 0, 1, 2 and 3 (`cfg_sel`=2, low 3 bits) subtract 0, 6, 12 and 18 codes. The subtraction saturates at 0.
- R7: A scale setting of 4, and any setting above 4, forces the resolved code to 0.
- R8: The resolved code never exceeds the limit. The clamp is applied after the scale reduction, so a request of 40 at scale 1 under a limit of 30 gives 30.
- R9: Every accepted request (`req_valid` and `req_ready` high at a rising edge) gives exactly one `out_valid` pulse in the next cycle. Back-to-back requests give back-to-back results in order.
- R10: `req_ready` is low in any cycle with `tbl_wr_en` high. A request offered in that cycle is not accepted and produces no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Setting write strobe |
| cfg_sel | input | 2 | 0 ceiling, 1 limit, 2 scale, 3 table-control enable |
| cfg_wdata | input | PWR_W | Setting write value |
| lim_rd | output | PWR_W | Stored (clamped) limit |
| tbl_wr_en | input | 1 | Table write strobe |
| tbl_wr_addr | input | IDX_W | Table word address |
| tbl_wr_data | input | TBL_DW | Table word value |
| req_valid | input | 1 | Frame request valid |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_power | input | PWR_W | Frame's requested power code |
| req_use_tbl | input | 1 | Frame asks for table-based power |
| req_tbl_idx | input | IDX_W | Frame's table index |
| out_valid | output | 1 | Resolved code valid |
| out_power | output | PWR_W | Resolved power code |

## Verification
The bench builds the block with its default parameters: a 7-bit power code, a 64-word table and 6-bit table words. With a 7-bit code the reset ceiling of 127 and every scale step fit in range. The test can also set a ceiling below a later limit write and see the clamp. With a 64-word table the test can load and read both end indices, 0 and 63. It can also hit the saturation boundary of the largest scale step, where requests of 18 and 19 give 0 and 1.

// File: rtl/txpwr_pkg.sv
package txpwr_pkg;

    // Setting selector codes on the write port
    typedef enum logic [1:0] {
        SEL_CEIL   = 2'd0,
        SEL_LIMIT  = 2'd1,
        SEL_SCALE  = 2'd2,
        SEL_TBL_EN = 2'd3
    } cfg_sel_e;

    localparam int SCALE_W   = 3;
    localparam int SCALE_TOP = 4;   // setting that forces minimum power

endpackage

// File: rtl/txpwr_cfg_regs.sv
module txpwr_cfg_regs
    import txpwr_pkg::*;
#(
    parameter int PWR_W = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [1:0]           sel,
    input  logic [PWR_W-1:0]     wdata,
    output logic [PWR_W-1:0]     ceil_o,
    output logic [PWR_W-1:0]     limit_o,
    output logic [SCALE_W-1:0]   scale_o,
    output logic                 tbl_en_o
);

    typedef struct packed {
        logic [PWR_W-1:0]   ceil;
        logic [PWR_W-1:0]   limit;
        logic [SCALE_W-1:0] scale;
        logic               tbl_en;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            unique case (cfg_sel_e'(sel))
                SEL_CEIL: begin
                    cfg_d.ceil = wdata;
                    if (cfg_q.limit > wdata)
                        cfg_d.limit = wdata;
                end
                SEL_LIMIT: begin
                    cfg_d.limit = (wdata > cfg_q.ceil) ? cfg_q.ceil : wdata;
                end
                SEL_SCALE: begin
                    if (wdata[SCALE_W-1:0] > SCALE_W'(SCALE_TOP))
                        cfg_d.scale = SCALE_W'(SCALE_TOP);
                    else
                        cfg_d.scale = wdata[SCALE_W-1:0];
                end
                SEL_TBL_EN: begin
                    cfg_d.tbl_en = wdata[0];
                end
                default: cfg_d = cfg_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.ceil   <= '1;
            cfg_q.limit  <= '1;
            cfg_q.scale  <= '0;
            cfg_q.tbl_en <= 1'b0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign ceil_o   = cfg_q.ceil;
    assign limit_o  = cfg_q.limit;
    assign scale_o  = cfg_q.scale;
    assign tbl_en_o = cfg_q.tbl_en;

endmodule

// File: rtl/txpwr_table.sv
module txpwr_table #(
    parameter int DEPTH = 64,
    parameter int DW    = 6,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DW-1:0]     rd_data
);

    logic [DW-1:0] mem_d [DEPTH];
    logic [DW-1:0] mem_q [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++)
            mem_d[i] = mem_q[i];
        if (wr_en && (int'(wr_addr) < DEPTH))
            mem_d[wr_addr] = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++)
                mem_q[i] <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++)
                mem_q[i] <= mem_d[i];
        end
    end

    always_comb begin
        rd_data = '0;
        if (int'(rd_idx) < DEPTH)
            rd_data = mem_q[rd_idx];
    end

endmodule

// File: rtl/txpwr_resolve.sv
module txpwr_resolve
    import txpwr_pkg::*;
#(
    parameter int PWR_W    = 7,
    parameter int TBL_DW   = 6,
    parameter int STEP_HDB = 6
) (
    input  logic [PWR_W-1:0]   req_power,
    input  logic               use_tbl,
    input  logic               tbl_en,
    input  logic [TBL_DW-1:0]  tbl_word,
    input  logic [SCALE_W-1:0] scale,
    input  logic [PWR_W-1:0]   limit,
    output logic [PWR_W-1:0]   power
);

    localparam int EXT_W = PWR_W + SCALE_W + 4;

    logic [PWR_W-1:0] tbl_ext;
    logic [PWR_W-1:0] base;
    logic [EXT_W-1:0] base_ext;
    logic [EXT_W-1:0] cut;
    logic [PWR_W-1:0] reduced;

    // Widen the table word to the power code width
    generate
        if (PWR_W > TBL_DW) begin : g_pad
            assign tbl_ext = {{(PWR_W-TBL_DW){1'b0}}, tbl_word};
        end else begin : g_trim
            assign tbl_ext = tbl_word[PWR_W-1:0];
        end
    endgenerate

    always_comb begin
        base     = (use_tbl && tbl_en) ? tbl_ext : req_power;
        base_ext = EXT_W'(base);
        cut      = EXT_W'(scale) * EXT_W'(STEP_HDB);
        if (scale >= SCALE_W'(SCALE_TOP))
            reduced = '0;
        else if (base_ext > cut)
            reduced = PWR_W'(base_ext - cut);
        else
            reduced = '0;
        power = (reduced > limit) ? limit : reduced;
    end

endmodule

// File: rtl/txpwr_resolver.sv
module txpwr_resolver
    import txpwr_pkg::*;
#(
    parameter int PWR_W     = 7,
    parameter int TBL_DEPTH = 64,
    parameter int TBL_DW    = 6,
    parameter int STEP_HDB  = 6,
    localparam int IDX_W    = (TBL_DEPTH > 1) ? $clog2(TBL_DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [1:0]        cfg_sel,
    input  logic [PWR_W-1:0]  cfg_wdata,
    output logic [PWR_W-1:0]  lim_rd,
    input  logic              tbl_wr_en,
    input  logic [IDX_W-1:0]  tbl_wr_addr,
    input  logic [TBL_DW-1:0] tbl_wr_data,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [PWR_W-1:0]  req_power,
    input  logic              req_use_tbl,
    input  logic [IDX_W-1:0]  req_tbl_idx,
    output logic              out_valid,
    output logic [PWR_W-1:0]  out_power
);

    typedef struct packed {
        logic             valid;
        logic [PWR_W-1:0] power;
    } out_t;

    logic [PWR_W-1:0]   ceil_q;
    logic [PWR_W-1:0]   limit_q;
    logic [SCALE_W-1:0] scale_q;
    logic               tbl_en_q;
    logic [TBL_DW-1:0]  tbl_word;
    logic [PWR_W-1:0]   resolved;
    out_t               out_d, out_q;

    txpwr_cfg_regs #(.PWR_W(PWR_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_wr_en),
        .sel      (cfg_sel),
        .wdata    (cfg_wdata),
        .ceil_o   (ceil_q),
        .limit_o  (limit_q),
        .scale_o  (scale_q),
        .tbl_en_o (tbl_en_q)
    );

    txpwr_table #(.DEPTH(TBL_DEPTH), .DW(TBL_DW)) u_tbl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (tbl_wr_en),
        .wr_addr (tbl_wr_addr),
        .wr_data (tbl_wr_data),
        .rd_idx  (req_tbl_idx),
        .rd_data (tbl_word)
    );

    txpwr_resolve #(.PWR_W(PWR_W), .TBL_DW(TBL_DW), .STEP_HDB(STEP_HDB)) u_res (
        .req_power (req_power),
        .use_tbl   (req_use_tbl),
        .tbl_en    (tbl_en_q),
        .tbl_word  (tbl_word),
        .scale     (scale_q),
        .limit     (limit_q),
        .power     (resolved)
    );

    // Table writes own the storage port for their cycle
    assign req_ready = !tbl_wr_en;

    always_comb begin
        out_d.valid = req_valid && req_ready;
        out_d.power = (req_valid && req_ready) ? resolved : out_q.power;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign out_valid = out_q.valid;
    assign out_power = out_q.power;
    assign lim_rd    = limit_q;

endmodule

// File: rtl/txpwr_resolver_chk.sv
module txpwr_resolver_chk #(
    parameter int PWR_W   = 7,
    parameter int SCALE_W = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_ready,
    input logic [PWR_W-1:0]   req_power,
    input logic               tbl_wr_en,
    input logic               out_valid,
    input logic [PWR_W-1:0]   out_power,
    input logic [PWR_W-1:0]   ceil_q,
    input logic [PWR_W-1:0]   limit_q,
    input logic [SCALE_W-1:0] scale_q,
    input logic               tbl_en_q
);

    AST_LIMIT_UNDER_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
        limit_q <= ceil_q);  // R2

    AST_OUT_UNDER_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_power <= $past(limit_q));  // R8

    AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> out_valid);  // R9

    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_ready) |=> !out_valid);  // R9

    AST_TOP_SCALE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && ($past(scale_q) >= SCALE_W'(4))) |-> out_power == '0);  // R7

    AST_TBL_OFF_NO_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !$past(tbl_en_q)) |-> out_power <= $past(req_power));  // R4

    AST_WRITE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_wr_en |-> !req_ready);  // R10

endmodule

bind txpwr_resolver txpwr_resolver_chk #(.PWR_W(PWR_W), .SCALE_W(txpwr_pkg::SCALE_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_power (req_power),
    .tbl_wr_en (tbl_wr_en),
    .out_valid (out_valid),
    .out_power (out_power),
    .ceil_q    (ceil_q),
    .limit_q   (limit_q),
    .scale_q   (scale_q),
    .tbl_en_q  (tbl_en_q)
);

// File: tb/test_txpwr_resolver.sv
`timescale 1ns/1ps
module test_txpwr_resolver;

    localparam int PWR_W = 7;
    localparam int DEPTH = 64;
    localparam int DW    = 6;
    localparam int IDX_W = 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_wr_en = 1'b0;
    logic [1:0]       cfg_sel = '0;
    logic [PWR_W-1:0] cfg_wdata = '0;
    logic [PWR_W-1:0] lim_rd;
    logic             tbl_wr_en = 1'b0;
    logic [IDX_W-1:0] tbl_wr_addr = '0;
    logic [DW-1:0]    tbl_wr_data = '0;
    logic             req_valid = 1'b0;
    logic             req_ready;
    logic [PWR_W-1:0] req_power = '0;
    logic             req_use_tbl = 1'b0;
    logic [IDX_W-1:0] req_tbl_idx = '0;
    logic             out_valid;
    logic [PWR_W-1:0] out_power;

    always #2 clk = ~clk;  // 250 MHz

    txpwr_resolver i_txpwr_resolver (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr_en(cfg_wr_en), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .lim_rd(lim_rd),
        .tbl_wr_en(tbl_wr_en), .tbl_wr_addr(tbl_wr_addr), .tbl_wr_data(tbl_wr_data),
        .req_valid(req_valid), .req_ready(req_ready), .req_power(req_power),
        .req_use_tbl(req_use_tbl), .req_tbl_idx(req_tbl_idx),
        .out_valid(out_valid), .out_power(out_power)
    );

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    // Bench-side model of the settings
    int m_ceil = 127, m_lim = 127, m_scale = 0;
    bit m_en = 1'b0;
    int m_tbl [DEPTH];

    int    exp_q [$];
    string tag_q [$];

    task automatic check(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int model(input int p, input bit use_t, input int idx);
        int base, sc, red;
        base = (use_t && m_en) ? m_tbl[idx] : p;
        sc   = (m_scale > 4) ? 4 : m_scale;
        if (sc == 4) red = 0;
        else red = (base > sc * 6) ? base - sc * 6 : 0;
        return (red > m_lim) ? m_lim : red;
    endfunction

    task automatic cfg_write(input int sel, input int val);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_sel = 2'(sel); cfg_wdata = PWR_W'(val);
        @(negedge clk);
        cfg_wr_en = 1'b0;
        case (sel)
            0: begin m_ceil = val; if (m_lim > val) m_lim = val; end
            1: m_lim = (val > m_ceil) ? m_ceil : val;
            2: m_scale = val & 7;
            default: m_en = val[0];
        endcase
    endtask

    task automatic tbl_write(input int idx, input int val);
        @(negedge clk);
        tbl_wr_en = 1'b1; tbl_wr_addr = IDX_W'(idx); tbl_wr_data = DW'(val);
        @(negedge clk);
        tbl_wr_en = 1'b0;
        m_tbl[idx] = val;
    endtask

    // Driver: one request, expected value pushed to the scoreboard
    task automatic send(input string tag, input int p, input bit use_t, input int idx);
        @(negedge clk);
        req_valid = 1'b1; req_power = PWR_W'(p); req_use_tbl = use_t; req_tbl_idx = IDX_W'(idx);
        exp_q.push_back(model(p, use_t, idx));
        tag_q.push_back(tag);
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Monitor
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (exp_q.size() == 0) begin
                check("R10 unexpected output", 1, 0);
            end else begin
                check(tag_q.pop_front(), int'(out_power), exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog all-requirements actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) m_tbl[i] = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 out_valid", int'(out_valid), 0);
        check("R1 lim_rd", int'(lim_rd), 127);
        check("R1 req_ready", int'(req_ready), 1);
        rst_n = 1'b1;
        @(negedge clk);
        send("R1 default pass", 40, 1'b1, 5); idle();
        send("R8 full code", 127, 1'b0, 0); idle();

        // R2 / R3 clamping
        cfg_write(0, 80);
        cfg_write(1, 100);
        check("R2 clamped readback", int'(lim_rd), 80);
        cfg_write(1, 50);
        check("R2 plain readback", int'(lim_rd), 50);
        cfg_write(0, 30);
        check("R3 ceiling lowers limit", int'(lim_rd), 30);
        cfg_write(0, 100);
        check("R3 ceiling raise keeps limit", int'(lim_rd), 30);
        send("R8 clamp to limit", 60, 1'b0, 0); idle();
        cfg_write(1, 100);
        send("R8 under limit", 60, 1'b0, 0); idle();

        // R4 / R5 table
        tbl_write(0, 5);
        tbl_write(17, 33);
        tbl_write(63, 63);
        send("R4 table off", 44, 1'b1, 17); idle();
        cfg_write(3, 1);
        send("R5 idx17", 44, 1'b1, 17); idle();
        send("R5 idx63", 10, 1'b1, 63); idle();
        send("R5 idx0", 90, 1'b1, 0); idle();
        send("R5 no table flag", 44, 1'b0, 63); idle();

        // R6 / R7 scale
        cfg_write(2, 1); send("R6 scale1", 40, 1'b0, 0); idle();
        cfg_write(2, 2); send("R6 scale2", 40, 1'b0, 0); idle();
        cfg_write(2, 3);
        send("R6 sat 10", 10, 1'b0, 0); idle();
        send("R6 sat 18", 18, 1'b0, 0); idle();
        send("R6 edge 19", 19, 1'b0, 0); idle();
        cfg_write(2, 4); send("R7 scale4", 100, 1'b0, 0); idle();
        cfg_write(2, 7); send("R7 scale7", 100, 1'b1, 63); idle();

        // R8 ordering: scale then clamp
        cfg_write(2, 1);
        cfg_write(1, 30);
        send("R8 order", 40, 1'b0, 0); idle();

        // R9 back-to-back
        send("R9 b2b a", 20, 1'b0, 0);
        send("R9 b2b b", 25, 1'b1, 17);
        send("R9 b2b c", 29, 1'b0, 0);
        idle();
        @(negedge clk);
        check("R9 all drained", exp_q.size(), 0);

        // R10 table write blocks requests
        @(negedge clk);
        tbl_wr_en = 1'b1; tbl_wr_addr = 6'd3; tbl_wr_data = 6'd9;
        req_valid = 1'b1; req_power = 7'd12; req_use_tbl = 1'b0;
        #1;
        check("R10 ready low", int'(req_ready), 0);
        @(negedge clk);
        tbl_wr_en = 1'b0; req_valid = 1'b0; m_tbl[3] = 9;
        repeat (2) @(negedge clk);
        check("R10 no output", int'(out_valid), 0);
        send("R5 after blocked write", 12, 1'b1, 3); idle();

        repeat (3) @(negedge clk);
        check("R9 scoreboard empty", exp_q.size(), 0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule